// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns a segment selector and an effective address into a linear address. A mode input chooses between two ways of doing this. In protected mode, the selector points at a descriptor in one of two internal tables, a global one and a local one, and the 32-bit base taken from that descriptor is added to the effective address. In real mode no table is used: the 16-bit selector is multiplied by sixteen and added to the low 16 bits of the effective address, which gives a 20-bit address inside a 1 MiB space.

Each table is loaded through its own write port with whole 8-byte descriptors. A request presents the selector, the effective address, the mode and the paging-enable bit. One cycle later the block returns the linear address with a valid strobe. It also returns a flag that says whether the address must go on to page translation. When paging is off, the same value comes out as the physical address. A protected-mode selector whose index lies past the end of a table raises an error strobe instead of the valid strobe.

Top module: `seg_linear_addr`

## Requirements
- R1: In protected mode, selector bit 2 picks the table: 0 reads the global table, 1 reads the local table.
- R2: In protected mode, selector bits 15:3 are the descriptor index inside the chosen table.
- R3: The base is assembled from the descriptor as base[23:0] = descriptor bits 39:16 (bytes 2 to 4) and base[31:24] = descriptor bits 63:56 (byte 7). All other descriptor bits are ignored.
- R4: The protected-mode linear address is base plus eff_addr, taken modulo 2^32.
- R5: In real mode (prot_en = 0), lin_addr = (selector * 16 + eff_addr[15:0]) mod 2^20, and lin_addr[31:20] is 0. eff_addr[31:16], selector bit 2 and the table contents have no effect.
- R6: xlate equals the paging_en given with the request. When xlate is 0, phys_addr equals lin_addr. When xlate is 1, phys_addr is 0.
- R7: A protected-mode index of 32 or more gives out_err = 1 and out_valid = 0 for that request. Real-mode requests never give an error.
- R8: out_valid or out_err pulses exactly one cycle after a cycle with req = 1. Neither is high in a cycle that follows one with req = 0. Both are 0 after reset.
- R9: When tbl_we = 1 at a clock edge, tbl_data is written to entry tbl_addr of the table named by tbl_sel (0 global, 1 local). The new contents are seen by requests in later cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tbl_we | input | 1 | Descriptor write enable |
| tbl_sel | input | 1 | Table to write: 0 global, 1 local |
| tbl_addr | input | 5 | Entry to write |
| tbl_data | input | 64 | Descriptor to write |
| req | input | 1 | Request strobe |
| prot_en | input | 1 | 1 protected mode, 0 real mode |
| paging_en | input | 1 | Paging-enable bit for the request |
| selector | input | 16 | Segment selector |
| eff_addr | input | 32 | Effective address |
| out_valid | output | 1 | Result valid |
| out_err | output | 1 | Index out of range |
| lin_addr | output | 32 | Linear address |
| xlate | output | 1 | Result goes to page translation |
| phys_addr | output | 32 | Physical address when paging is off |

## Verification
Random protected-mode requests go to both tables, with descriptors whose ignored bytes hold random data. This separates a wrong table pick, a wrong index slice or wrong byte placement in the base. Real-mode requests carry random upper effective-address bits and random table bits to show that these have no effect. Directed cases push the protected sum past 2^32 and the real sum past 2^20, and give the indices 31 and 32 at the table edge. Paging is switched on and off at random, so both the routing flag and the zeroed physical output are checked in each mode.

// File: rtl/seg_linear_addr.sv
module seg_linear_addr #(
  parameter int ENTRIES = 32,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tbl_we,
  input  logic        tbl_sel,
  input  logic [IW-1:0] tbl_addr,
  input  logic [63:0] tbl_data,
  input  logic        req,
  input  logic        prot_en,
  input  logic        paging_en,
  input  logic [15:0] selector,
  input  logic [31:0] eff_addr,
  output logic        out_valid,
  output logic        out_err,
  output logic [31:0] lin_addr,
  output logic        xlate,
  output logic [31:0] phys_addr
);

  logic [63:0] gdt [ENTRIES];
  logic [63:0] ldt [ENTRIES];

  always_ff @(posedge clk)
    if (tbl_we) begin
      if (tbl_sel) ldt[tbl_addr] <= tbl_data;
      else         gdt[tbl_addr] <= tbl_data;
    end

  logic [12:0]   idx;
  logic [IW-1:0] ridx;
  logic [63:0]   desc;
  logic [31:0]   base;
  logic          bad;
  logic [19:0]   real_sum;
  logic [31:0]   lin_d;

  assign idx      = selector[15:3];
  assign ridx     = idx[IW-1:0];
  assign desc     = selector[2] ? ldt[ridx] : gdt[ridx];
  assign base     = {desc[63:56], desc[39:16]};
  assign bad      = prot_en && (idx >= 13'(ENTRIES));
  assign real_sum = {selector, 4'h0} + {4'h0, eff_addr[15:0]};
  assign lin_d    = prot_en ? base + eff_addr : {12'h0, real_sum};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      lin_addr  <= '0;
      xlate     <= 1'b0;
      phys_addr <= '0;
    end else begin
      out_valid <= req && !bad;
      out_err   <= req && bad;
      if (req) begin
        lin_addr  <= lin_d;
        xlate     <= paging_en;
        phys_addr <= paging_en ? 32'h0 : lin_d;
      end
    end

endmodule

module seg_linear_addr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        prot_en,
  input logic        paging_en,
  input logic        out_valid,
  input logic        out_err,
  input logic [31:0] lin_addr,
  input logic        xlate,
  input logic [31:0] phys_addr
);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !out_valid && !out_err);
  a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> out_valid || out_err);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_err));
  a_r7_real_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    req && !prot_en |=> !out_err);
  a_r5_real_20bit: assert property (@(posedge clk) disable iff (!rst_n)
    req && !prot_en |=> lin_addr[31:20] == 12'h0);
  a_r6_route: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> xlate == $past(paging_en));
  a_r6_phys: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> phys_addr == (xlate ? 32'h0 : lin_addr));
endmodule

bind seg_linear_addr seg_linear_addr_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .prot_en(prot_en),
  .paging_en(paging_en), .out_valid(out_valid), .out_err(out_err),
  .lin_addr(lin_addr), .xlate(xlate), .phys_addr(phys_addr)
);

// File: tb/test_seg_linear_addr.sv
`timescale 1ns/1ps
module test_seg_linear_addr;
  logic clk = 0, rst_n = 0;
  logic tbl_we = 0, tbl_sel = 0;
  logic [4:0] tbl_addr = 0;
  logic [63:0] tbl_data = 0;
  logic req = 0, prot_en = 0, paging_en = 0;
  logic [15:0] selector = 0;
  logic [31:0] eff_addr = 0;
  logic out_valid, out_err, xlate;
  logic [31:0] lin_addr, phys_addr;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [63:0] mdl [2][32];

  always #4 clk = ~clk;

  seg_linear_addr i_seg_linear_addr (.*);

  function automatic logic [31:0] exp_lin(bit p, logic [15:0] s, logic [31:0] e);
    logic [63:0] d;
    logic [19:0] r;
    if (p) begin
      d = mdl[s[2]][s[7:3]];
      return {d[63:56], d[39:16]} + e;
    end
    r = {s, 4'h0} + {4'h0, e[15:0]};
    return {12'h0, r};
  endfunction

  task automatic check(string req_tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", req_tag, what, act, exp);
    end
  endtask

  task automatic load(bit t, logic [4:0] a, logic [63:0] d);
    @(negedge clk);
    tbl_we = 1; tbl_sel = t; tbl_addr = a; tbl_data = d;
    @(negedge clk);
    tbl_we = 0;
    mdl[t][a] = d;
  endtask

  task automatic apply(string tag, bit p, bit pg, logic [15:0] s, logic [31:0] e);
    bit bad;
    logic [31:0] el;
    @(negedge clk);
    req = 1; prot_en = p; paging_en = pg; selector = s; eff_addr = e;
    @(negedge clk);
    req = 0;
    bad = p && (s[15:3] >= 13'd32);
    check(tag, "out_err", 32'(out_err), 32'(bad));
    check(tag, "out_valid", 32'(out_valid), 32'(!bad));
    if (!bad) begin
      el = exp_lin(p, s, e);
      check(tag, "lin_addr", lin_addr, el);
      check(tag, "xlate", 32'(xlate), 32'(pg));
      check(tag, "phys_addr", phys_addr, pg ? 32'h0 : el);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8", "reset out_valid", 32'(out_valid), 0);
    check("R8", "reset out_err", 32'(out_err), 0);
    rst_n = 1;
    void'($urandom(32'h5eed));
    for (int t = 0; t < 2; t++)
      for (int a = 0; a < 32; a++)
        load(t[0], a[4:0], {$urandom, $urandom});
    // R1/R2/R3: same index, two tables, distinct bases
    load(0, 5'd3, 64'h11AA_BBBB_2233_44CC);
    load(1, 5'd3, 64'h55DD_EEEE_6677_88FF);
    apply("R1", 1, 0, 16'h0018, 32'h0);
    apply("R1", 1, 0, 16'h001C, 32'h0);
    // R4: wrap modulo 2^32
    load(0, 5'd31, 64'hFF00_00FF_FFFF_0000);
    apply("R4", 1, 0, 16'h00F8, 32'h2);
    // R7: index 31 valid, 32 error in both tables
    apply("R7", 1, 1, 16'h00FC, 32'h10);
    apply("R7", 1, 0, 16'h0100, 32'h10);
    apply("R7", 1, 0, 16'hFFFF, 32'h10);
    // R5: real mode carry out of bit 19 dropped, upper eff ignored
    apply("R5", 0, 0, 16'hFFFF, 32'hABCD_FFFF);
    apply("R5", 0, 1, 16'h1234, 32'h0000_0005);
    apply("R5", 0, 0, 16'hFFFF, 32'h0);
    // R8: no pulse without a request
    @(negedge clk);
    check("R8", "idle out_valid", 32'(out_valid), 0);
    check("R8", "idle out_err", 32'(out_err), 0);
    // R9: rewrite and reread
    load(1, 5'd9, 64'h0102_0304_0506_0708);
    apply("R9", 1, 0, 16'h004C, 32'h100);
    // random mix: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 600; i++) begin
      logic [15:0] s;
      bit p;
      p = $urandom_range(0, 3) != 0;
      s = $urandom;
      if ($urandom_range(0, 4) != 0) s[15:8] = 8'h0;
      apply(p ? "R4" : "R5", p, $urandom_range(0, 1) == 1, s, $urandom);
      if (i % 50 == 0)
        load($urandom_range(0, 1) == 1, 5'($urandom_range(0, 31)), {$urandom, $urandom});
    end
    finish_run();
  end
endmodule